// File: doc/BRIEF.md
# Asynchronous Serial Transceiver Channel

This block is the serial datapath of one asynchronous serial channel. The surrounding logic supplies a baud enable that pulses sixteen times per bit, plus the frame settings: character length, parity enable and parity sense. A parallel character handed to the transmitter is sent on the serial output as a framed character. The receiver watches its serial input, rebuilds characters, and reports them together with parity, framing and overrun flags.

The transmitter and the receiver have separate sequencers, so a character can be sent while another is being received. A self-test switch connects the transmit stream to the receiver inside the block. While the switch is on, the external serial output stays at the idle level and the external serial input is not used. The frame settings must stay constant while a character is in flight.

Top module: `serial_xcvr`

## Requirements
- R1: A transmitted frame is one low start bit, then `5 + charLen` data bits sent least significant bit first (charLen 0..3 gives 5..8 bits), then an optional parity bit, then one high stop bit. Each bit lasts 16 baud ticks. With no frame in progress, txOut is high.
- R2: When parityEn is 1, a parity bit follows the data. With parityOdd = 0 it makes the number of ones over data plus parity even. With parityOdd = 1 it makes that number odd. When parityEn is 0, no parity bit is sent.
- R3: The receiver detects a low level on a baud tick and samples the line 8 ticks later, then every 16 ticks. After the stop bit it presents the character on rxData, with every bit above the character length at zero, and sets rxValid.
- R4: parityErr is 1 for a delivered character whose received parity bit differs from the one R2 would generate. It is always 0 when parityEn is 0.
- R5: frameErr is 1 for a delivered character whose stop bit was sampled low.
- R6: A start bit that is high again at its mid-point sample is discarded, and no character is delivered.
- R7: If a character is delivered while rxValid is still 1 and rxRead is 0, overrunErr is set and rxData holds the newer character. A cycle with rxRead high clears rxValid and overrunErr.
- R8: With loopEn = 1, the receiver takes its input from the transmit stream, txOut is held high, and rxIn has no effect.
- R9: The transmitter and receiver run independently, so a frame can be sent and another received at the same time, both correctly.
- R10: txStart is accepted only while txBusy is 0. txBusy is 1 from the cycle after acceptance until the stop bit ends, and a txStart pulse while busy is ignored.
- R11: After reset, txOut is high, and txBusy, rxValid, parityErr, frameErr and overrunErr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle enable, 16 per bit |
| charLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| loopEn | input | 1 | Internal self-test loop |
| txData | input | 8 | Character to send |
| txStart | input | 1 | Request to send txData |
| txBusy | output | 1 | Frame in progress |
| txOut | output | 1 | Serial output, idle high |
| rxIn | input | 1 | Serial input |
| rxRead | input | 1 | Consume the received character |
| rxData | output | 8 | Last received character |
| rxValid | output | 1 | Unread character present |
| parityErr | output | 1 | Parity mismatch on rxData |
| frameErr | output | 1 | Low stop bit on rxData |
| overrunErr | output | 1 | Unread character overwritten |

## Verification
The transmitter is driven with random data under random length and parity settings. A bench decoder samples each bit cell at its centre and separates the data bits, the parity sense and the stop level. The receiver gets randomly framed characters, some with a deliberately wrong parity bit, which tells a genuine parity check apart from a flag that is always quiet. Directed cases cover all four lengths, a shortened low stop bit, a start pulse only three ticks long, two characters with no read between them, loopback with rxIn held low, and overlapping transmit and receive traffic that would expose any shared state between the two directions.

// File: rtl/serx_pkg.sv
package serx_pkg;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PARITY
  } lineSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } frameState_e;

  typedef struct packed {
    logic     txLoad;
    logic     txShift;
    lineSel_e txSel;
    logic     rxClear;
    logic     rxTakeBit;
    logic     rxTakePar;
    logic     rxDeliver;
  } xcvrStrobe_t;

endpackage

// File: rtl/serx_ctrl.sv
module serx_ctrl
  import serx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MIN_BITS      = 5,
  parameter int MAX_BITS      = 8,
  localparam int TW = $clog2(TICKS_PER_BIT),
  localparam int IW = $clog2(MAX_BITS),
  localparam int LW = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          baudTick,
  input  logic [LW-1:0] charLen,
  input  logic          parityEn,
  input  logic          txStart,
  input  logic          rxLine,
  output xcvrStrobe_t   stb,
  output logic [IW-1:0] rxBitIdx,
  output logic          txBusy
);

  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);
  localparam logic [TW-1:0] MID_TICK  = TW'(TICKS_PER_BIT / 2 - 1);

  logic [IW-1:0] lastIdx;
  assign lastIdx = IW'(MIN_BITS - 1) + IW'(charLen);

  // transmit sequencer
  frameState_e   txSt;
  logic [TW-1:0] txTicks;
  logic [IW-1:0] txBit;
  logic          txBitEnd;

  assign txBitEnd = baudTick && (txTicks == LAST_TICK);
  assign txBusy   = (txSt != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSt    <= ST_IDLE;
      txTicks <= '0;
      txBit   <= '0;
    end else if (txSt == ST_IDLE) begin
      if (txStart) begin
        txSt    <= ST_START;
        txTicks <= '0;
        txBit   <= '0;
      end
    end else begin
      if (baudTick) txTicks <= txBitEnd ? '0 : txTicks + 1'b1;
      if (txBitEnd) begin
        case (txSt)
          ST_START:  txSt <= ST_DATA;
          ST_DATA: begin
            if (txBit == lastIdx) txSt <= parityEn ? ST_PARITY : ST_STOP;
            else                  txBit <= txBit + 1'b1;
          end
          ST_PARITY: txSt <= ST_STOP;
          default:   txSt <= ST_IDLE;
        endcase
      end
    end
  end

  // receive sequencer
  frameState_e   rxSt;
  logic [TW-1:0] rxTicks;
  logic [IW-1:0] rxBit;
  logic          rxBitEnd;
  logic          rxMid;

  assign rxBitEnd = baudTick && (rxTicks == LAST_TICK);
  assign rxMid    = baudTick && (rxTicks == MID_TICK);
  assign rxBitIdx = rxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt    <= ST_IDLE;
      rxTicks <= '0;
      rxBit   <= '0;
    end else begin
      case (rxSt)
        ST_IDLE: begin
          if (baudTick && !rxLine) begin
            rxSt    <= ST_START;
            rxTicks <= '0;
            rxBit   <= '0;
          end
        end
        ST_START: begin
          if (rxMid) begin
            rxTicks <= '0;
            rxSt    <= rxLine ? ST_IDLE : ST_DATA;
          end else if (baudTick) begin
            rxTicks <= rxTicks + 1'b1;
          end
        end
        default: begin
          if (baudTick) rxTicks <= rxBitEnd ? '0 : rxTicks + 1'b1;
          if (rxBitEnd) begin
            case (rxSt)
              ST_DATA: begin
                if (rxBit == lastIdx) rxSt <= parityEn ? ST_PARITY : ST_STOP;
                else                  rxBit <= rxBit + 1'b1;
              end
              ST_PARITY: rxSt <= ST_STOP;
              default:   rxSt <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // strobes toward the datapath
  always_comb begin
    stb           = '0;
    stb.txLoad    = (txSt == ST_IDLE) && txStart;
    stb.txShift   = txBitEnd && (txSt == ST_DATA);
    case (txSt)
      ST_START:  stb.txSel = LINE_SPACE;
      ST_DATA:   stb.txSel = LINE_DATA;
      ST_PARITY: stb.txSel = LINE_PARITY;
      default:   stb.txSel = LINE_MARK;
    endcase
    stb.rxClear   = (rxSt == ST_IDLE) && baudTick && !rxLine;
    stb.rxTakeBit = rxBitEnd && (rxSt == ST_DATA);
    stb.rxTakePar = rxBitEnd && (rxSt == ST_PARITY);
    stb.rxDeliver = rxBitEnd && (rxSt == ST_STOP);
  end

endmodule

// File: rtl/serx_dpath.sv
module serx_dpath
  import serx_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8,
  localparam int IW = $clog2(MAX_BITS),
  localparam int LW = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  xcvrStrobe_t         stb,
  input  logic [IW-1:0]       rxBitIdx,
  input  logic [LW-1:0]       charLen,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                loopEn,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                rxIn,
  input  logic                rxRead,
  output logic                txOut,
  output logic                rxLine,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxValid,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrunErr
);

  // bits that belong to the selected character length
  logic [MAX_BITS-1:0] lenMask;
  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign lenMask[i] = (i < MIN_BITS + int'(charLen));
  end

  // transmit side
  logic [MAX_BITS-1:0] txShreg;
  logic                txParBit;
  logic                txLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShreg  <= '0;
      txParBit <= 1'b0;
    end else if (stb.txLoad) begin
      txShreg  <= txData & lenMask;
      txParBit <= (^(txData & lenMask)) ^ parityOdd;
    end else if (stb.txShift) begin
      txShreg  <= txShreg >> 1;
    end
  end

  always_comb begin
    case (stb.txSel)
      LINE_SPACE:  txLine = 1'b0;
      LINE_DATA:   txLine = txShreg[0];
      LINE_PARITY: txLine = txParBit;
      default:     txLine = 1'b1;
    endcase
  end

  assign txOut = loopEn | txLine;

  // receive side
  logic [1:0]          rxSync;
  logic [MAX_BITS-1:0] rxShreg;
  logic                rxParBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxIn};
  end

  assign rxLine = loopEn ? txLine : rxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShreg  <= '0;
      rxParBit <= 1'b0;
    end else if (stb.rxClear) begin
      rxShreg  <= '0;
    end else if (stb.rxTakeBit) begin
      rxShreg[rxBitIdx] <= rxLine;
    end else if (stb.rxTakePar) begin
      rxParBit <= rxLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxValid    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else if (stb.rxDeliver) begin
      rxData     <= rxShreg;
      rxValid    <= 1'b1;
      parityErr  <= parityEn && (rxParBit != ((^rxShreg) ^ parityOdd));
      frameErr   <= !rxLine;
      overrunErr <= rxValid && !rxRead;
    end else if (rxRead) begin
      rxValid    <= 1'b0;
      overrunErr <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import serx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MIN_BITS      = 5,
  parameter int MAX_BITS      = 8,
  localparam int IW = $clog2(MAX_BITS),
  localparam int LW = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick,
  input  logic [LW-1:0]       charLen,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                loopEn,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                txStart,
  output logic                txBusy,
  output logic                txOut,
  input  logic                rxIn,
  input  logic                rxRead,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxValid,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrunErr
);

  xcvrStrobe_t   stb;
  logic [IW-1:0] rxBitIdx;
  logic          rxLine;

  serx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .MIN_BITS     (MIN_BITS),
    .MAX_BITS     (MAX_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .charLen (charLen),
    .parityEn(parityEn),
    .txStart (txStart),
    .rxLine  (rxLine),
    .stb     (stb),
    .rxBitIdx(rxBitIdx),
    .txBusy  (txBusy)
  );

  serx_dpath #(
    .MIN_BITS(MIN_BITS),
    .MAX_BITS(MAX_BITS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rxBitIdx  (rxBitIdx),
    .charLen   (charLen),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .loopEn    (loopEn),
    .txData    (txData),
    .rxIn      (rxIn),
    .rxRead    (rxRead),
    .txOut     (txOut),
    .rxLine    (rxLine),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .overrunErr(overrunErr)
  );

endmodule

// File: rtl/serx_checker.sv
module serx_checker (
  input logic clk,
  input logic rstN,
  input logic txStart,
  input logic txBusy,
  input logic txOut,
  input logic loopEn,
  input logic parityEn,
  input logic rxRead,
  input logic rxValid,
  input logic parityErr,
  input logic overrunErr,
  input logic deliver
);

  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !loopEn) |-> txOut);

  a_r10_start_only_on_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(txStart));

  a_r8_loop_line_high: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> txOut);

  a_r3_valid_after_deliver: assert property (@(posedge clk) disable iff (!rstN)
    deliver |=> rxValid);

  a_r4_no_parity_flag_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (deliver && !parityEn) |=> !parityErr);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !deliver) |=> (!rxValid && !overrunErr));

  a_r7_overrun_needs_unread: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(rxValid));

endmodule

bind serial_xcvr serx_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txStart   (txStart),
  .txBusy    (txBusy),
  .txOut     (txOut),
  .loopEn    (loopEn),
  .parityEn  (parityEn),
  .rxRead    (rxRead),
  .rxValid   (rxValid),
  .parityErr (parityErr),
  .overrunErr(overrunErr),
  .deliver   (stb.rxDeliver)
);

// File: tb/tb_serial_xcvr.sv
`timescale 1ns/1ps
module tb_serial_xcvr;

  localparam int BITCLK = 64; // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       loopEn = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txStart = 1'b0;
  logic       txBusy;
  logic       txOut;
  logic       rxIn = 1'b1;
  logic       rxRead = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       parityErr;
  logic       frameErr;
  logic       overrunErr;

  int vectors = 0;
  int errors  = 0;
  int tickCnt = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tickCnt  <= (tickCnt + 1) % 4;
    baudTick <= (tickCnt == 3);
  end

  serial_xcvr dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .loopEn(loopEn),
    .txData(txData), .txStart(txStart), .txBusy(txBusy), .txOut(txOut),
    .rxIn(rxIn), .rxRead(rxRead), .rxData(rxData), .rxValid(rxValid),
    .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr)
  );

  function automatic logic [7:0] maskOf(input int len);
    return 8'((16'd1 << len) - 1);
  endfunction

  function automatic logic parOf(input logic [7:0] d, input int len, input logic odd);
    return (^(d & maskOf(len))) ^ odd;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input int len, input logic pen, input logic podd);
    @(negedge clk);
    charLen   = 2'(len - 5);
    parityEn  = pen;
    parityOdd = podd;
  endtask

  task automatic pulseTx(input logic [7:0] d);
    @(negedge clk);
    txData  = d;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
  endtask

  task automatic readRx();
    @(negedge clk);
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  // decode one frame from txOut, sampling at bit centres
  task automatic captureTx(input int len, input logic pen, output logic startB,
                           output logic [7:0] d, output logic parB, output logic stopB);
    int n = 0;
    d = 8'h00;
    parB = 1'b0;
    while (txOut !== 1'b0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (BITCLK / 2) @(negedge clk);
    startB = txOut;
    for (int i = 0; i < len; i++) begin
      repeat (BITCLK) @(negedge clk);
      d[i] = txOut;
    end
    if (pen) begin
      repeat (BITCLK) @(negedge clk);
      parB = txOut;
    end
    repeat (BITCLK) @(negedge clk);
    stopB = txOut;
  endtask

  task automatic sendRx(input logic [7:0] d, input int len, input logic pen, input logic podd,
                        input logic badPar, input logic stopLow);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rxIn = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (pen) begin
      rxIn = parOf(d, len, podd) ^ badPar;
      repeat (BITCLK) @(negedge clk);
    end
    if (stopLow) begin
      rxIn = 1'b0;
      repeat (44) @(negedge clk);
      rxIn = 1'b1;
      repeat (BITCLK - 44) @(negedge clk);
    end else begin
      rxIn = 1'b1;
      repeat (BITCLK) @(negedge clk);
    end
  endtask

  task automatic txCase(input string tag, input logic [7:0] d, input int len,
                        input logic pen, input logic podd);
    logic sb, pb, stb2;
    logic [7:0] got;
    setCfg(len, pen, podd);
    fork
      captureTx(len, pen, sb, got, pb, stb2);
      pulseTx(d);
    join
    chk({tag, " R1 start"}, 32'(sb), 32'd0);
    chk({tag, " R1 data"}, 32'(got), 32'(d & maskOf(len)));
    if (pen) chk({tag, " R2 parity"}, 32'(pb), 32'(parOf(d, len, podd)));
    chk({tag, " R1 stop"}, 32'(stb2), 32'd1);
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic rxCase(input string tag, input logic [7:0] d, input int len,
                        input logic pen, input logic podd, input logic badPar);
    setCfg(len, pen, podd);
    sendRx(d, len, pen, podd, badPar, 1'b0);
    chk({tag, " R3 valid"}, 32'(rxValid), 32'd1);
    chk({tag, " R3 data"}, 32'(rxData), 32'(d & maskOf(len)));
    chk({tag, " R4 parityErr"}, 32'(parityErr), 32'(pen & badPar));
    chk({tag, " R5 frameErr"}, 32'(frameErr), 32'd0);
    readRx();
    chk({tag, " R7 cleared"}, 32'(rxValid), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 txOut", 32'(txOut), 32'd1);
    chk("R11 txBusy", 32'(txBusy), 32'd0);
    chk("R11 rxValid", 32'(rxValid), 32'd0);
    chk("R11 flags", {29'd0, parityErr, frameErr, overrunErr}, 32'd0);

    // R1 every character length, directed
    for (int l = 5; l <= 8; l++) txCase("dir", 8'hA5, l, 1'b0, 1'b0);
    // R1 R2 random transmit
    for (int k = 0; k < 10; k++)
      txCase("rnd", 8'($urandom), 5 + int'($urandom_range(3)),
             1'($urandom_range(1)), 1'($urandom_range(1)));

    // R3 R4 directed receive, every length
    for (int l = 5; l <= 8; l++) rxCase("dir", 8'h5A ^ 8'(l), l, 1'b1, 1'(l & 1), 1'b0);
    // R3 R4 random receive with some bad parity
    for (int k = 0; k < 10; k++)
      rxCase("rnd", 8'($urandom), 5 + int'($urandom_range(3)),
             1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)));
    rxCase("R4 odd bad", 8'hFF, 8, 1'b1, 1'b1, 1'b1);

    // R5 framing error
    setCfg(8, 1'b0, 1'b0);
    sendRx(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 valid", 32'(rxValid), 32'd1);
    chk("R5 frameErr", 32'(frameErr), 32'd1);
    chk("R5 data", 32'(rxData), 32'h3C);
    readRx();
    repeat (4 * BITCLK) @(negedge clk);
    chk("R5 no extra char", 32'(rxValid), 32'd0);

    // R6 glitch rejection
    @(negedge clk);
    rxIn = 1'b0;
    repeat (12) @(negedge clk);
    rxIn = 1'b1;
    repeat (12 * BITCLK) @(negedge clk);
    chk("R6 glitch ignored", 32'(rxValid), 32'd0);

    // R7 overrun
    setCfg(7, 1'b0, 1'b0);
    sendRx(8'h11, 7, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 first no overrun", 32'(overrunErr), 32'd0);
    sendRx(8'h62, 7, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun set", 32'(overrunErr), 32'd1);
    chk("R7 newer data", 32'(rxData), 32'h62);
    readRx();
    chk("R7 overrun cleared", 32'(overrunErr), 32'd0);
    chk("R7 valid cleared", 32'(rxValid), 32'd0);

    // R10 txStart ignored while busy
    begin
      logic sb, pb, sp;
      logic [7:0] got;
      int falls = 0;
      setCfg(8, 1'b0, 1'b0);
      fork
        captureTx(8, 1'b0, sb, got, pb, sp);
        begin
          pulseTx(8'hC3);
          chk("R10 busy", 32'(txBusy), 32'd1);
          repeat (200) @(negedge clk);
          pulseTx(8'h18);
        end
      join
      chk("R10 first kept", 32'(got), 32'hC3);
      repeat (BITCLK) @(negedge clk);
      chk("R10 idle after", 32'(txBusy), 32'd0);
      for (int c = 0; c < 12 * BITCLK; c++) begin
        @(negedge clk);
        if (txOut !== 1'b1) falls++;
      end
      chk("R10 no second frame", 32'(falls), 32'd0);
    end

    // R8 loopback
    begin
      int lows = 0;
      setCfg(6, 1'b1, 1'b0);
      @(negedge clk);
      loopEn = 1'b1;
      @(negedge clk);
      rxIn = 1'b0;
      fork
        pulseTx(8'h2D);
        for (int c = 0; c < 11 * BITCLK; c++) begin
          @(negedge clk);
          if (txOut !== 1'b1) lows++;
        end
      join
      chk("R8 txOut held high", 32'(lows), 32'd0);
      chk("R8 loop valid", 32'(rxValid), 32'd1);
      chk("R8 loop data", 32'(rxData), 32'h2D);
      chk("R8 loop parity ok", 32'(parityErr), 32'd0);
      readRx();
      rxIn = 1'b1;
      repeat (8) @(negedge clk);
      loopEn = 1'b0;
      repeat (2 * BITCLK) @(negedge clk);
      chk("R8 rxIn ignored", 32'(rxValid), 32'd0);
    end

    // R9 simultaneous transmit and receive
    for (int k = 0; k < 3; k++) begin
      logic sb, pb, sp;
      logic [7:0] got;
      logic [7:0] tx = 8'($urandom);
      logic [7:0] rx = 8'($urandom);
      setCfg(8, 1'b1, 1'b1);
      fork
        captureTx(8, 1'b1, sb, got, pb, sp);
        pulseTx(tx);
        sendRx(rx, 8, 1'b1, 1'b1, 1'b0, 1'b0);
      join
      chk("R9 tx data", 32'(got), 32'(tx));
      chk("R9 tx parity", 32'(pb), 32'(parOf(tx, 8, 1'b1)));
      chk("R9 rx data", 32'(rxData), 32'(rx));
      chk("R9 rx parity ok", 32'(parityErr), 32'd0);
      readRx();
      repeat (BITCLK) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule